// File: doc/BRIEF.md
# I2C High-Speed Mode Tracker

This block lives inside an I2C target. It oversamples the bus lines with the system clock and reports the bus speed mode to the rest of the device. Standard/fast mode is the default. High-speed mode is entered only through one fixed sequence: a START, a master-code byte, a released (high) SDA on that byte's ninth clock, and then a repeated START. Once entered, high-speed mode lasts across any number of bytes and repeated STARTs, and it ends only on a STOP.

The block also does the plain bus bookkeeping that other logic needs:
- It detects START, repeated START and STOP conditions.
- It frames each byte, eight data clocks plus one acknowledge clock.
- It strobes every received byte and marks the first byte after each START or repeated START.

The device's acknowledge logic sends its drive request through the block. The block masks that request during the master-code byte, so the target never acknowledges a master code.

Top module: `hs_speed_tracker`

## Requirements
- R1: While the synchronous active-low reset `rstN` is low, and after its release, the block is idle in standard/fast mode: `hsMode` is 0 and no pulse or byte strobe is asserted.
- R2: SDA falling while SCL is high, with no transfer in progress, gives one `startPulse`. SDA rising while SCL is high gives one `stopPulse` and ends the transfer.
- R3: A START seen while a transfer is in progress gives one `rstartPulse` and no `startPulse`.
- R4: Data bits are taken on SCL rising edges, most significant bit first. After the eighth bit, `byteValid` is high for exactly one cycle with the byte on `byteData`. The ninth, acknowledge, clock never produces a byte strobe.
- R5: `isFirstByte` is high with the strobe of the first byte after each START or repeated START, and low for every later byte.
- R6: If the first byte after a START has bits [7:3] equal to 00001 (bits [2:0] are ignored), SDA is high on its ninth clock, and a repeated START follows, then `hsMode` becomes 1.
- R7: While `hsMode` is 1, it stays 1 across data bytes and across further repeated STARTs.
- R8: A STOP always clears `hsMode` to 0.
- R9: A first byte whose bits [7:3] are not 00001 never leads to `hsMode` = 1, even when a repeated START follows.
- R10: A master code whose ninth clock sees SDA low does not lead to high-speed mode after the following repeated START.
- R11: A master code with a released ninth clock that is followed by a STOP instead of a repeated START returns the block to idle with `hsMode` never set. The next START is then reported as a plain START.
- R12: `sdaDriveReq` follows `ackReq`, except that it is held at 0 from the end of the eighth bit of a master-code byte through that byte's ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Synchronous active-low reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| ackReq | input | 1 | Acknowledge drive request from the device logic |
| hsMode | output | 1 | 1 = high-speed mode, 0 = standard/fast mode |
| sdaDriveReq | output | 1 | Gated SDA pull-low request toward the pad |
| byteValid | output | 1 | One-cycle strobe when a byte is complete |
| byteData | output | 8 | Received byte, valid with `byteValid` |
| isFirstByte | output | 1 | Qualifies `byteValid` as the first byte after a (repeated) START |
| startPulse | output | 1 | One-cycle pulse on a START from idle |
| rstartPulse | output | 1 | One-cycle pulse on a repeated START |
| stopPulse | output | 1 | One-cycle pulse on a STOP |

## Verification
The hardest state to reach is the narrow window between a master code's not-acknowledge and the repeated START. In that window the mode must still be standard/fast, the drive request must be masked for exactly one clock, and the next condition decides everything. The stimulus reaches it by sweeping all 256 first-byte values through the same frame: START, byte with released ninth clock, repeated START, address, data, a second repeated START, then STOP. Each run is compared against the arithmetic master-code match on bits [7:3]. Separate frames then steer the same window into an acknowledged master code and into an immediate STOP.

// File: rtl/hst_pkg.sv
package hst_pkg;
  localparam int DATA_BITS   = 8;
  localparam int MC_PREFIX_W = 5;
  localparam logic [MC_PREFIX_W-1:0] MC_PREFIX = 5'b00001;

  // Strobes from the bus datapath to the mode control
  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
    logic byteDone;
    logic ninthDone;
    logic nack;
  } busEvt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_MC_ACK,
    ST_MC_WAIT,
    ST_XFER,
    ST_HS
  } speedSt_t;
endpackage

// File: rtl/hst_datapath.sv
module hst_datapath
  import hst_pkg::*;
#(
  parameter int BITS = DATA_BITS,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  output busEvt_t         evt,
  output logic [BITS-1:0] byteData,
  output logic            firstFlag
);
  localparam int CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] LAST_DATA = CW'(BITS - 1);
  localparam logic [CW-1:0] ACK_SLOT  = CW'(BITS);

  logic [SYNC-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclS, sdaS;
  logic startCond, stopCond, sclRise;
  logic busy, firstPend;
  logic [CW-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS      = sclSync[SYNC-1];
  assign sdaS      = sdaSync[SYNC-1];
  assign startCond = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopCond  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sclRise   = sclS & ~sclPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evt       <= '0;
      busy      <= 1'b0;
      firstPend <= 1'b0;
      firstFlag <= 1'b0;
      bitCnt    <= '0;
      byteData  <= '0;
    end else begin
      evt <= '0;
      if (startCond) begin
        evt.start  <= ~busy;
        evt.rstart <= busy;
        busy       <= 1'b1;
        firstPend  <= 1'b1;
        bitCnt     <= '0;
      end else if (stopCond) begin
        evt.stop  <= 1'b1;
        busy      <= 1'b0;
        firstPend <= 1'b0;
        bitCnt    <= '0;
      end else if (sclRise && busy) begin
        if (bitCnt == ACK_SLOT) begin
          evt.ninthDone <= 1'b1;
          evt.nack      <= sdaS;
          bitCnt        <= '0;
        end else begin
          byteData <= {byteData[BITS-2:0], sdaS};
          bitCnt   <= bitCnt + 1'b1;
          if (bitCnt == LAST_DATA) begin
            evt.byteDone <= 1'b1;
            firstFlag    <= firstPend;
            firstPend    <= 1'b0;
          end
        end
      end
    end
  end

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= ACK_SLOT);
  a_r2_evt_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evt.start, evt.rstart, evt.stop, evt.byteDone, evt.ninthDone}));
  a_r3_rstart_in_xfer: assert property (@(posedge clk) disable iff (!rstN)
    evt.rstart |-> $past(busy));
endmodule

// File: rtl/hst_control.sv
module hst_control
  import hst_pkg::*;
#(
  parameter int BITS = DATA_BITS
) (
  input  logic            clk,
  input  logic            rstN,
  input  busEvt_t         evt,
  input  logic [BITS-1:0] byteData,
  input  logic            ackReq,
  output logic            hsMode,
  output logic            sdaDriveReq
);
  speedSt_t state, stateNx;
  logic isMc;

  assign isMc = (byteData[BITS-1 -: MC_PREFIX_W] == MC_PREFIX);

  always_comb begin
    stateNx = state;
    if (evt.stop) begin
      stateNx = ST_IDLE;
    end else if (evt.start || evt.rstart) begin
      if (state == ST_MC_WAIT || state == ST_HS) stateNx = ST_HS;
      else                                       stateNx = ST_FIRST;
    end else begin
      case (state)
        ST_FIRST:  if (evt.byteDone)  stateNx = isMc ? ST_MC_ACK : ST_XFER;
        ST_MC_ACK: if (evt.ninthDone) stateNx = evt.nack ? ST_MC_WAIT : ST_XFER;
        default:   stateNx = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNx;
  end

  assign hsMode      = (state == ST_HS);
  assign sdaDriveReq = ackReq & (state != ST_MC_ACK);

  a_r6_entry_on_rstart: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsMode) |-> $past(evt.rstart));
  a_r7_hs_holds: assert property (@(posedge clk) disable iff (!rstN)
    (hsMode && !evt.stop) |=> hsMode);
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    evt.stop |=> !hsMode);
endmodule

// File: rtl/hs_speed_tracker.sv
module hs_speed_tracker
  import hst_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 ackReq,
  output logic                 hsMode,
  output logic                 sdaDriveReq,
  output logic                 byteValid,
  output logic [DATA_BITS-1:0] byteData,
  output logic                 isFirstByte,
  output logic                 startPulse,
  output logic                 rstartPulse,
  output logic                 stopPulse
);
  busEvt_t evt;
  logic firstFlag;

  hst_datapath #(.BITS(DATA_BITS), .SYNC(SYNC)) i_datapath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .evt(evt), .byteData(byteData), .firstFlag(firstFlag)
  );

  hst_control #(.BITS(DATA_BITS)) i_control (
    .clk(clk), .rstN(rstN), .evt(evt), .byteData(byteData),
    .ackReq(ackReq), .hsMode(hsMode), .sdaDriveReq(sdaDriveReq)
  );

  assign byteValid   = evt.byteDone;
  assign isFirstByte = evt.byteDone & firstFlag;
  assign startPulse  = evt.start;
  assign rstartPulse = evt.rstart;
  assign stopPulse   = evt.stop;
endmodule

// File: tb/test_hs_speed_tracker.sv
`timescale 1ns/1ps
module test_hs_speed_tracker;
  localparam int PH = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1, sda = 1'b1, ackReq = 1'b1;
  logic hsMode, sdaDriveReq, byteValid, isFirstByte, startPulse, rstartPulse, stopPulse;
  logic [7:0] byteData;

  int checks = 0, fails = 0;
  int startCnt = 0, rstartCnt = 0, stopCnt = 0, byteCnt = 0, firstCnt = 0, anyCnt = 0;
  logic [7:0] lastByte = '0, lastFirst = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hs_speed_tracker i_hs_speed_tracker (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda), .ackReq(ackReq),
    .hsMode(hsMode), .sdaDriveReq(sdaDriveReq), .byteValid(byteValid),
    .byteData(byteData), .isFirstByte(isFirstByte), .startPulse(startPulse),
    .rstartPulse(rstartPulse), .stopPulse(stopPulse)
  );

  always @(negedge clk) begin
    if (startPulse)  startCnt++;
    if (rstartPulse) rstartCnt++;
    if (stopPulse)   stopCnt++;
    if (startPulse || rstartPulse || stopPulse || byteValid) anyCnt++;
    if (byteValid) begin
      byteCnt++;
      lastByte = byteData;
      if (isFirstByte) begin
        firstCnt++;
        lastFirst = byteData;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitPh(input int n);
    repeat (n * PH) @(negedge clk);
  endtask

  task automatic doStart();
    sda = 1'b1; waitPh(1);
    scl = 1'b1; waitPh(1);
    sda = 1'b0; waitPh(1);
    scl = 1'b0; waitPh(1);
  endtask

  task automatic doStop();
    sda = 1'b0; waitPh(1);
    scl = 1'b1; waitPh(1);
    sda = 1'b1; waitPh(2);
  endtask

  task automatic sendBit(input logic b);
    sda = b; waitPh(1);
    scl = 1'b1; waitPh(2);
    scl = 1'b0; waitPh(1);
  endtask

  task automatic sendByte(input logic [7:0] d, input logic ninth, input logic expDrive);
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    sda = ninth; waitPh(1);
    chk(sdaDriveReq == expDrive, "R12", sdaDriveReq, expDrive);
    scl = 1'b1; waitPh(2);
    scl = 1'b0; waitPh(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int s0, r0, p0, b0, f0;
    logic [7:0] bv;
    logic isMc;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(hsMode == 1'b0, "R1", hsMode, 0);
    chk(anyCnt == 0, "R1", anyCnt, 0);
    rstN = 1'b1;
    waitPh(4);
    chk(hsMode == 1'b0 && anyCnt == 0, "R1", anyCnt, 0);

    // Sweep all first-byte values: R2..R9, R12
    for (int b = 0; b < 256; b++) begin
      bv = b[7:0];
      isMc = (bv[7:3] == 5'b00001);
      s0 = startCnt; r0 = rstartCnt; p0 = stopCnt; b0 = byteCnt; f0 = firstCnt;
      doStart();
      sendByte(bv, 1'b1, !isMc);
      chk(lastFirst == bv, "R5", lastFirst, bv);
      chk(hsMode == 1'b0, "R6", hsMode, 0);
      doStart();
      chk(rstartCnt - r0 == 1 && startCnt - s0 == 1, "R3", rstartCnt - r0, 1);
      sendByte(8'hA6, 1'b0, 1'b1);
      chk(hsMode == isMc, isMc ? "R6" : "R9", hsMode, isMc);
      sendByte(8'h3C, 1'b0, 1'b1);
      chk(lastByte == 8'h3C, "R4", lastByte, 8'h3C);
      chk(hsMode == isMc, isMc ? "R7" : "R9", hsMode, isMc);
      doStart();
      sendByte(8'hA7, 1'b0, 1'b1);
      chk(hsMode == isMc, isMc ? "R7" : "R9", hsMode, isMc);
      chk(lastFirst == 8'hA7, "R5", lastFirst, 8'hA7);
      doStop();
      waitPh(2);
      chk(hsMode == 1'b0, "R8", hsMode, 0);
      chk(stopCnt - p0 == 1 && startCnt - s0 == 1, "R2", stopCnt - p0, 1);
      chk(byteCnt - b0 == 4, "R4", byteCnt - b0, 4);
      chk(firstCnt - f0 == 3, "R5", firstCnt - f0, 3);
    end

    // R10: master code acknowledged
    doStart();
    sendByte(8'h0B, 1'b0, 1'b0);
    doStart();
    sendByte(8'hA6, 1'b0, 1'b1);
    chk(hsMode == 1'b0, "R10", hsMode, 0);
    doStop();
    waitPh(2);

    // R11: master code then STOP
    doStart();
    sendByte(8'h09, 1'b1, 1'b0);
    doStop();
    waitPh(2);
    chk(hsMode == 1'b0, "R11", hsMode, 0);
    s0 = startCnt; r0 = rstartCnt;
    doStart();
    waitPh(1);
    chk(startCnt - s0 == 1 && rstartCnt == r0, "R11", startCnt - s0, 1);
    sendByte(8'hA6, 1'b0, 1'b1);
    chk(hsMode == 1'b0, "R11", hsMode, 0);
    doStop();
    waitPh(2);

    // R12: drive request passes through when low
    ackReq = 1'b0;
    waitPh(1);
    chk(sdaDriveReq == 1'b0, "R12", sdaDriveReq, 0);
    ackReq = 1'b1;
    waitPh(1);
    chk(sdaDriveReq == 1'b1, "R12", sdaDriveReq, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule